// File: doc/BRIEF.md
# Streaming Lookup-Table Access Port

This block sits between a simple register bus and the storage of two lookup tables: a small X table and a larger Y table. Software selects the table, chooses read or write access and names a first entry with one write to a configuration register. After that it moves entries through a single data register. Each access targets the entry under an internal pointer, and the pointer then steps by one. A whole table is loaded with one configuration write and one data write per entry. No address write is needed per entry.

The tables are shared with a datapath that reads them during processing. An idle input from that datapath gates every table write. A write attempted while the datapath is busy is dropped and recorded in a sticky error flag. Reads return one cycle after the request and may start at any entry. Table memories are external. The block drives one chip select per table, plus a shared address, write enable and write data, and it takes a synchronous read result back from each table.

Top module: `lut_access_port`

## Requirements
- R1: After reset, the configuration readback word is all zeros: table X, read access, error clear, pointer 0. No memory chip select is active.
- R2: A configuration write takes the table from bit 0 (0 = X, 1 = Y) and the access type from bit 1 (0 = read, 1 = write). For read access, it loads the pointer from bits 24:16.
- R3: A configuration write with write access sets the pointer to 0, whatever bits 24:16 hold.
- R4: In write access with idle high and the pointer inside the table, a data-register write stores bits 15:0 at the pointer in the selected table, and the pointer advances by one.
- R5: A data-register read returns the entry at the pointer in bits 15:0, with bits 31:16 zero. The read-valid strobe is high exactly in the cycle after the request, and the pointer advances by one.
- R6: A data-register write in write access while idle is low leaves both tables and the pointer unchanged and sets the error flag.
- R7: The error flag stays set through later accesses until the next configuration write, which clears it.
- R8: A data-register write while the access type is read changes neither table, the pointer nor the error flag.
- R9: When the pointer is at or past the table depth (65 for X, 257 for Y), data accesses touch no memory and leave the pointer where it is, and reads return zero.
- R10: A read of the configuration register returns, one cycle later, bit 0 = table, bit 1 = access type, bit 3 = error flag and bits 24:16 = current pointer. Read-valid is low in every cycle that does not follow a read request.
- R11: At most one table chip select is active in a cycle, and a memory write happens only while idle is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset (0 = configuration, 4 = data) |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| idle_i | input | 1 | Datapath idle; table writes are allowed only while high |
| mem_x_cs | output | 1 | X table chip select |
| mem_y_cs | output | 1 | Y table chip select |
| mem_we | output | 1 | Write enable for the selected table |
| mem_addr | output | 9 | Entry address |
| mem_wdata | output | 16 | Entry write data |
| mem_x_rdata | input | 16 | X table read data, valid the cycle after a read |
| mem_y_rdata | input | 16 | Y table read data, valid the cycle after a read |

## Verification
Full sequential loads of both tables check that the write path always starts at entry 0 and stops at the depth. Read-back from chosen starting entries near each end separates correct pointer loading from an off-by-one step, and tells the X and Y depth limits apart. Writes issued with idle low, and writes issued in read access, separate the two kinds of suppressed write by their effect on the error flag. A long random mix of configuration changes, reads, writes and idle toggling is compared against a bench model of pointer, flag and table contents, so stale pointers or a wrong table selection show up as data mismatches.

// File: rtl/lut_port_pkg.sv
package lut_port_pkg;

   typedef enum logic {
      TBL_X = 1'b0,
      TBL_Y = 1'b1
   } tbl_e;

   typedef enum logic {
      ACC_RD = 1'b0,
      ACC_WR = 1'b1
   } acc_e;

   typedef struct packed {
      logic cfg_wr;
      logic cfg_rd;
      logic dat_wr;
      logic dat_rd;
      logic oth_rd;
   } bus_op_t;

endpackage

// File: rtl/lut_bus_decode.sv
module lut_bus_decode
   import lut_port_pkg::*;
#(
   parameter int                REG_AW   = 4,
   parameter logic [REG_AW-1:0] CFG_OFS  = '0,
   parameter logic [REG_AW-1:0] DATA_OFS = 4
) (
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [REG_AW-1:0] addr_i,
   output bus_op_t           op_o
);

   if (CFG_OFS == DATA_OFS) begin : g_bad_ofs
      $error("configuration and data offsets must differ");
   end

   logic hit_cfg, hit_dat;

   always_comb begin
      hit_cfg     = (addr_i == CFG_OFS);
      hit_dat     = (addr_i == DATA_OFS);
      op_o.cfg_wr = req_i &  wr_i & hit_cfg;
      op_o.cfg_rd = req_i & ~wr_i & hit_cfg;
      op_o.dat_wr = req_i &  wr_i & hit_dat;
      op_o.dat_rd = req_i & ~wr_i & hit_dat;
      op_o.oth_rd = req_i & ~wr_i & ~hit_cfg & ~hit_dat;
   end

endmodule

// File: rtl/lut_cfg_reg.sv
module lut_cfg_reg
   import lut_port_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int PTR_W     = 9,
   parameter int START_LSB = 16,
   parameter int TBL_BIT   = 0,
   parameter int ACC_BIT   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic             err_set_i,
   output tbl_e             tbl_o,
   output acc_e             acc_o,
   output logic             err_o,
   output logic [PTR_W-1:0] start_o
);

   if (START_LSB + PTR_W > BUS_W) begin : g_bad_start
      $error("start field does not fit the bus word");
   end
   if (TBL_BIT == ACC_BIT) begin : g_bad_bits
      $error("table and access bits must differ");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   assign start_o = wdata_i[ACC_BIT] ? '0 : wdata_i[START_LSB +: PTR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_o <= TBL_X;
         acc_o <= ACC_RD;
         err_o <= 1'b0;
      end else if (load_i) begin
         tbl_o <= tbl_e'(wdata_i[TBL_BIT]);
         acc_o <= acc_e'(wdata_i[ACC_BIT]);
         err_o <= 1'b0;
      end else if (err_set_i) begin
         err_o <= 1'b1;
      end
   end

endmodule

// File: rtl/lut_ptr_ctr.sv
module lut_ptr_ctr
   import lut_port_pkg::*;
#(
   parameter int PTR_W   = 9,
   parameter int X_DEPTH = 65,
   parameter int Y_DEPTH = 257
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] load_val_i,
   input  logic             step_i,
   input  tbl_e             tbl_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             in_range_o
);

   localparam int NUM_TBL = 2;

   if ((X_DEPTH >= (1 << PTR_W)) || (Y_DEPTH >= (1 << PTR_W))) begin : g_bad_ptr
      $error("pointer too narrow for table depth");
   end

   logic [PTR_W-1:0] lim [NUM_TBL];

   for (genvar g = 0; g < NUM_TBL; g++) begin : g_lim
      assign lim[g] = PTR_W'((g == 0) ? X_DEPTH : Y_DEPTH);
   end

   assign in_range_o = (ptr_o < lim[tbl_i]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
      end else if (load_i) begin
         ptr_o <= load_val_i;
      end else if (step_i) begin
         ptr_o <= ptr_o + 1'b1;
      end
   end

endmodule

// File: rtl/lut_mem_route.sv
module lut_mem_route #(
   parameter int DATA_W  = 16,
   parameter int PTR_W   = 9,
   parameter int NUM_TBL = 2,
   localparam int SEL_W  = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en_i,
   input  logic                      we_i,
   input  logic [SEL_W-1:0]          sel_i,
   input  logic [PTR_W-1:0]          addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [NUM_TBL*DATA_W-1:0] rd_bus_i,
   output logic [NUM_TBL-1:0]        cs_o,
   output logic                      we_o,
   output logic [PTR_W-1:0]          addr_o,
   output logic [DATA_W-1:0]         wdata_o,
   output logic [DATA_W-1:0]         rdata_o
);

   logic [SEL_W-1:0] sel_q;

   for (genvar g = 0; g < NUM_TBL; g++) begin : g_cs
      assign cs_o[g] = en_i && (sel_i == SEL_W'(g));
   end

   assign we_o    = en_i & we_i;
   assign addr_o  = addr_i;
   assign wdata_o = wdata_i;
   assign rdata_o = rd_bus_i[sel_q*DATA_W +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (en_i && !we_i) begin
         sel_q <= sel_i;
      end
   end

endmodule

// File: rtl/lut_access_port.sv
module lut_access_port
   import lut_port_pkg::*;
#(
   parameter int                DATA_W    = 16,
   parameter int                BUS_W     = 32,
   parameter int                REG_AW    = 4,
   parameter logic [REG_AW-1:0] CFG_OFS   = 0,
   parameter logic [REG_AW-1:0] DATA_OFS  = 4,
   parameter int                X_DEPTH   = 65,
   parameter int                Y_DEPTH   = 257,
   parameter int                START_LSB = 16,
   parameter int                TBL_BIT   = 0,
   parameter int                ACC_BIT   = 1,
   parameter int                ERR_BIT   = 3,
   localparam int               MAX_DEPTH = (X_DEPTH > Y_DEPTH) ? X_DEPTH : Y_DEPTH,
   localparam int               PTR_W     = $clog2(MAX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic              bus_rvalid,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              idle_i,
   output logic              mem_x_cs,
   output logic              mem_y_cs,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_x_rdata,
   input  logic [DATA_W-1:0] mem_y_rdata
);

   if (DATA_W > BUS_W) begin : g_bad_data
      $error("entry width exceeds bus width");
   end
   if ((ERR_BIT == TBL_BIT) || (ERR_BIT == ACC_BIT) || (ERR_BIT >= START_LSB)) begin : g_bad_err
      $error("error bit overlaps another field");
   end

   bus_op_t          op;
   tbl_e             tbl;
   acc_e             acc;
   logic             err_q;
   logic [PTR_W-1:0] load_val;
   logic [PTR_W-1:0] ptr_q;
   logic             in_range;
   logic             acc_wr;
   logic             wr_ok, rd_ok, wr_blocked;
   logic [1:0]       cs;
   logic [DATA_W-1:0] mem_rd;
   logic [BUS_W-1:0] cfg_word;
   logic             rvalid_q, rmem_q;
   logic [BUS_W-1:0] snap_q;

   lut_bus_decode #(
      .REG_AW   (REG_AW),
      .CFG_OFS  (CFG_OFS),
      .DATA_OFS (DATA_OFS)
   ) dec_i (
      .req_i  (bus_req),
      .wr_i   (bus_wr),
      .addr_i (bus_addr),
      .op_o   (op)
   );

   assign acc_wr     = (acc == ACC_WR);
   assign wr_blocked = op.dat_wr & acc_wr & ~idle_i;
   assign wr_ok      = op.dat_wr & acc_wr & idle_i & in_range;
   assign rd_ok      = op.dat_rd & in_range;

   lut_cfg_reg #(
      .BUS_W     (BUS_W),
      .PTR_W     (PTR_W),
      .START_LSB (START_LSB),
      .TBL_BIT   (TBL_BIT),
      .ACC_BIT   (ACC_BIT)
   ) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (op.cfg_wr),
      .wdata_i   (bus_wdata),
      .err_set_i (wr_blocked),
      .tbl_o     (tbl),
      .acc_o     (acc),
      .err_o     (err_q),
      .start_o   (load_val)
   );

   lut_ptr_ctr #(
      .PTR_W   (PTR_W),
      .X_DEPTH (X_DEPTH),
      .Y_DEPTH (Y_DEPTH)
   ) ptr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (op.cfg_wr),
      .load_val_i (load_val),
      .step_i     (wr_ok | rd_ok),
      .tbl_i      (tbl),
      .ptr_o      (ptr_q),
      .in_range_o (in_range)
   );

   lut_mem_route #(
      .DATA_W  (DATA_W),
      .PTR_W   (PTR_W),
      .NUM_TBL (2)
   ) route_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (wr_ok | rd_ok),
      .we_i     (wr_ok),
      .sel_i    (tbl),
      .addr_i   (ptr_q),
      .wdata_i  (bus_wdata[DATA_W-1:0]),
      .rd_bus_i ({mem_y_rdata, mem_x_rdata}),
      .cs_o     (cs),
      .we_o     (mem_we),
      .addr_o   (mem_addr),
      .wdata_o  (mem_wdata),
      .rdata_o  (mem_rd)
   );

   assign mem_x_cs = cs[0];
   assign mem_y_cs = cs[1];

   always_comb begin
      cfg_word                       = '0;
      cfg_word[TBL_BIT]              = tbl;
      cfg_word[ACC_BIT]              = acc;
      cfg_word[ERR_BIT]              = err_q;
      cfg_word[START_LSB +: PTR_W]   = ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rmem_q   <= 1'b0;
         snap_q   <= '0;
      end else begin
         rvalid_q <= op.cfg_rd | op.dat_rd | op.oth_rd;
         rmem_q   <= rd_ok;
         snap_q   <= op.cfg_rd ? cfg_word : '0;
      end
   end

   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = rmem_q ? BUS_W'(mem_rd) : snap_q;

endmodule

// File: rtl/lut_access_port_chk.sv
module lut_access_port_chk #(
   parameter int                REG_AW   = 4,
   parameter logic [REG_AW-1:0] CFG_OFS  = 0,
   parameter logic [REG_AW-1:0] DATA_OFS = 4,
   parameter int                BUS_W    = 32,
   parameter int                PTR_W    = 9,
   parameter int                X_DEPTH  = 65,
   parameter int                Y_DEPTH  = 257,
   parameter int                ACC_BIT  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_wr,
   input logic [REG_AW-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              bus_rvalid,
   input logic              idle_i,
   input logic              mem_x_cs,
   input logic              mem_y_cs,
   input logic              mem_we,
   input logic [PTR_W-1:0]  mem_addr,
   input logic [PTR_W-1:0]  ptr,
   input logic              err,
   input logic              acc_wr
);

   localparam logic [PTR_W-1:0] X_LIM = PTR_W'(X_DEPTH);
   localparam logic [PTR_W-1:0] Y_LIM = PTR_W'(Y_DEPTH);

   logic cfg_w, dat_w, rd_req;
   assign cfg_w  = bus_req && bus_wr && (bus_addr == CFG_OFS);
   assign dat_w  = bus_req && bus_wr && (bus_addr == DATA_OFS);
   assign rd_req = bus_req && !bus_wr;

   AST_CFG_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_w && bus_wdata[ACC_BIT]) |=> (ptr == '0)); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_w && (mem_x_cs || mem_y_cs)) |=> (ptr == $past(ptr) + 1'b1)); // R4
   AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid); // R5
   AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_w && acc_wr && !idle_i) |=> (ptr == $past(ptr)) && err); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !cfg_w) |=> err); // R7
   AST_READMODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_w && !acc_wr) |-> !(mem_x_cs || mem_y_cs)); // R8
   AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_x_cs |-> (mem_addr < X_LIM)); // R9
   AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_y_cs |-> (mem_addr < Y_LIM)); // R9
   AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid); // R10
   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_x_cs, mem_y_cs})); // R11
   AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (idle_i && (mem_x_cs || mem_y_cs))); // R11

endmodule

bind lut_access_port lut_access_port_chk #(
   .REG_AW   (REG_AW),
   .CFG_OFS  (CFG_OFS),
   .DATA_OFS (DATA_OFS),
   .BUS_W    (BUS_W),
   .PTR_W    (PTR_W),
   .X_DEPTH  (X_DEPTH),
   .Y_DEPTH  (Y_DEPTH),
   .ACC_BIT  (ACC_BIT)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rvalid (bus_rvalid),
   .idle_i     (idle_i),
   .mem_x_cs   (mem_x_cs),
   .mem_y_cs   (mem_y_cs),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .ptr        (ptr_q),
   .err        (err_q),
   .acc_wr     (acc_wr)
);

// File: tb/lut_access_port_tb_top.sv
module lut_access_port_tb_top;

   localparam int XD = 65;
   localparam int YD = 257;
   localparam logic [3:0] A_CFG = 4'h0;
   localparam logic [3:0] A_DAT = 4'h4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        idle = 1'b1;
   logic        mem_x_cs, mem_y_cs, mem_we;
   logic [8:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] xr = '0, yr = '0;

   logic [15:0] mx [XD];
   logic [15:0] my [YD];
   logic [15:0] ex [XD];
   logic [15:0] ey [YD];

   int e_tbl, e_acc, e_err, e_ptr;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lut_access_port dut_i (
      .clk (clk), .rst_n (rst_n),
      .bus_req (bus_req), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rvalid (bus_rvalid), .bus_rdata (bus_rdata),
      .idle_i (idle),
      .mem_x_cs (mem_x_cs), .mem_y_cs (mem_y_cs), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_x_rdata (xr), .mem_y_rdata (yr)
   );

   always @(posedge clk) begin
      if (mem_x_cs && int'(mem_addr) < XD) begin
         if (mem_we) mx[mem_addr] <= mem_wdata;
         else        xr <= mx[mem_addr];
      end
      if (mem_y_cs && int'(mem_addr) < YD) begin
         if (mem_we) my[mem_addr] <= mem_wdata;
         else        yr <= my[mem_addr];
      end
   end

   function automatic int depth_of(int t);
      return (t == 1) ? YD : XD;
   endfunction

   function automatic logic [31:0] cfg_exp();
      return (32'(e_ptr) << 16) | (32'(e_err) << 3) | (32'(e_acc) << 1) | 32'(e_tbl);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic wr, input logic [3:0] a, input logic [31:0] d,
                            output logic [31:0] rd, output logic rv);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      rd = bus_rdata; rv = bus_rvalid;
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic cfg_write(input int t, input int a, input int start);
      logic [31:0] rd; logic rv;
      bus_cycle(1'b1, A_CFG, (32'(start & 511) << 16) | (32'(a) << 1) | 32'(t), rd, rv);
      e_tbl = t; e_acc = a; e_err = 0;
      e_ptr = (a == 1) ? 0 : (start & 511);
   endtask

   task automatic cfg_check(input string tag);
      logic [31:0] rd; logic rv;
      bus_cycle(1'b0, A_CFG, 32'h0, rd, rv);
      chk({tag, " cfg rvalid"}, 32'(rv), 32'd1);
      chk({tag, " cfg word"}, rd, cfg_exp());
   endtask

   task automatic dat_write(input logic [15:0] d);
      logic [31:0] rd; logic rv;
      bus_cycle(1'b1, A_DAT, {16'hA5A5, d}, rd, rv);
      if (e_acc == 1) begin
         if (!idle) e_err = 1;
         else if (e_ptr < depth_of(e_tbl)) begin
            if (e_tbl == 1) ey[e_ptr] = d; else ex[e_ptr] = d;
            e_ptr++;
         end
      end
   endtask

   task automatic dat_read(input string tag);
      logic [31:0] rd; logic rv; logic [31:0] exp;
      bus_cycle(1'b0, A_DAT, 32'h0, rd, rv);
      exp = '0;
      if (e_ptr < depth_of(e_tbl)) begin
         exp = {16'h0, (e_tbl == 1) ? ey[e_ptr] : ex[e_ptr]};
         e_ptr++;
      end
      chk({tag, " data rvalid"}, 32'(rv), 32'd1);
      chk({tag, " data word"}, rd, exp);
   endtask

   task automatic tables_cmp(input string tag);
      int bad = 0;
      for (int i = 0; i < XD; i++) if (mx[i] !== ex[i]) bad++;
      for (int i = 0; i < YD; i++) if (my[i] !== ey[i]) bad++;
      chk({tag, " table mismatches"}, 32'(bad), 32'd0);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < XD; i++) begin mx[i] = '0; ex[i] = '0; end
      for (int i = 0; i < YD; i++) begin my[i] = '0; ey[i] = '0; end
      e_tbl = 0; e_acc = 0; e_err = 0; e_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 chip selects", {30'h0, mem_x_cs, mem_y_cs}, 32'h0);
      chk("R1 rvalid", 32'(bus_rvalid), 32'h0);
      cfg_check("R1");

      // R3: write access ignores start field
      cfg_write(0, 1, 37);
      cfg_check("R3");

      // R4: full X load
      for (int i = 0; i < XD; i++) dat_write(16'($urandom));
      tables_cmp("R4 X load");
      cfg_check("R4 X end");
      // R9: write past end of X
      dat_write(16'hDEAD);
      tables_cmp("R9 X overrun write");
      cfg_check("R9 X overrun ptr");

      // R4: full Y load
      cfg_write(1, 1, 300);
      for (int i = 0; i < YD; i++) dat_write(16'($urandom));
      tables_cmp("R4 Y load");

      // R2 / R5 / R9: read-back from chosen starts
      cfg_write(1, 0, 250);
      cfg_check("R2 Y start");
      for (int i = 0; i < 7; i++) dat_read("R5 Y tail");
      dat_read("R9 Y past end");
      cfg_check("R9 Y ptr hold");
      cfg_write(0, 0, 0);
      for (int i = 0; i < 3; i++) dat_read("R5 X head");
      cfg_write(0, 0, 64);
      dat_read("R5 X last");
      dat_read("R9 X past end");
      cfg_check("R10 readback");

      // R6 / R7: blocked write and sticky flag
      cfg_write(0, 1, 0);
      idle = 1'b0;
      dat_write(16'hBEEF);
      tables_cmp("R6 no store");
      cfg_check("R6 flag");
      idle = 1'b1;
      dat_write(16'h1234);
      tables_cmp("R7 store after idle");
      cfg_check("R7 sticky");
      cfg_write(0, 1, 0);
      cfg_check("R7 cleared");

      // R8: write in read access
      cfg_write(1, 0, 5);
      dat_write(16'h5555);
      tables_cmp("R8 no store");
      cfg_check("R8 no change");

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op == 0) begin
            int t, a;
            t = int'($urandom_range(0, 1));
            a = int'($urandom_range(0, 1));
            cfg_write(t, a, int'($urandom_range(0, depth_of(t) + 3)));
         end else if (op <= 4) begin
            idle = ($urandom_range(0, 7) != 0);
            dat_write(16'($urandom));
            idle = 1'b1;
         end else if (op <= 8) begin
            dat_read("R5 random");
         end else begin
            cfg_check("R10 random");
         end
      end
      tables_cmp("R4 random final");

      finish_run();
   end

endmodule